// File: doc/BRIEF.md
# Programmable Logic Cell

This block models one configurable cell of a programmable logic fabric. A four-input lookup table takes its function from a 16-bit truth-table mask, and one register sits beside it with a full set of controls. Static configuration inputs decide where the two variable LUT inputs come from and what the register captures. They also decide whether each routing output shows the registered or the combinational value.

The register and the LUT can serve unrelated purposes. The register can capture a data pin directly, which is the packed mode. It can also take the register-chain input from the neighbouring cell, so that a row of cells forms a shift register while every LUT computes its own function. When feedback is enabled, the register output replaces one LUT input. Only the plain logic mode is modelled; carry arithmetic is not part of this cell.

Top module: `lcell`

## Requirements
- R1: The LUT result equals `cfg_lut[idx]`, where idx is formed from LUT inputs 3..0 (input 0 is the least significant bit). By default, LUT inputs 0..3 are `d_in[0]`..`d_in[3]`.
- R2: When `cfg_cin_sel` is 1, LUT input 2 is `cin` instead of `d_in[2]`. When `cfg_cin_sel` is 0, `cin` has no effect on the LUT result.
- R3: When `cfg_fb` is 1, LUT input 3 is the register output instead of `d_in[3]`. In that case `d_in[3]` has no effect on the LUT result.
- R4: While `aclr` is 1, the register reads 0 at once, without waiting for a clock edge, and ignores all other controls.
- R5: At a rising clock edge with `ena` at 0, the register keeps its value regardless of `sclr`, `sload` and the data inputs.
- R6: At a rising edge with `ena` and `sclr` both 1, the register becomes 0. This takes priority over `sload`.
- R7: At a rising edge with `ena` at 1, `sclr` at 0 and `sload` at 1, the register captures the packed data input `d_in[3]`.
- R8: At a rising edge with `ena` at 1 and both `sclr` and `sload` at 0, the register captures the source chosen by `cfg_src`. The codes are: 0 for the LUT result, 1 for `d_in[3]`, 2 for `chain_in`, and 3 for the LUT result.
- R9: `chain_out` always equals the register. Cells linked `chain_out` to `chain_in` with `cfg_src`=2 shift by one cell per enabled edge, and their LUT outputs keep following R1.
- R10: Each bit `route_o[i]` shows the register when `cfg_oreg[i]` is 1, and the combinational LUT result when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| aclr | input | 1 | Asynchronous clear, active high |
| ena | input | 1 | Clock enable for all synchronous updates |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of the packed data input |
| cfg_lut | input | 16 | LUT truth-table mask |
| cfg_cin_sel | input | 1 | 1: LUT input 2 comes from cin |
| cfg_fb | input | 1 | 1: LUT input 3 comes from the register |
| cfg_src | input | 2 | Register data source select |
| cfg_oreg | input | 3 | Per-output select, 1 = registered |
| d_in | input | 4 | Data inputs |
| cin | input | 1 | Carry-in from the previous cell |
| chain_in | input | 1 | Register-chain input |
| route_o | output | 3 | General routing outputs |
| chain_out | output | 1 | Register-chain output |

## Verification
A wrong register state shows on `chain_out` and on every routing output set to the registered value one cycle after the edge that caused it. With feedback on, it also corrupts the combinational LUT result in that same cycle. An input-select error changes only the combinational routing outputs and shows without any clock edge. In a cascade, a wrong shift appears at the next cell's `chain_out` one cycle later, so an error spreads down the row one cell per enabled edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LC_NDATA  = 4;
    localparam int LC_MASK_W = 1 << LC_NDATA;
    localparam int LC_NOUT   = 3;

    // register data source codes
    typedef enum logic [1:0] {
        SRC_LUT     = 2'd0,
        SRC_PACK    = 2'd1,
        SRC_CHAIN   = 2'd2,
        SRC_LUT_ALT = 2'd3
    } reg_src_e;

    // shared register controls
    typedef struct packed {
        logic ena;
        logic sclr;
        logic sload;
    } reg_ctl_t;

    // static input-routing options for the LUT
    typedef struct packed {
        logic cin_sel;
        logic fb;
    } lut_route_t;

    function automatic logic src_is_lut(reg_src_e s);
        return (s == SRC_LUT) || (s == SRC_LUT_ALT);
    endfunction

endpackage

// File: rtl/lcell_lut.sv
module lcell_lut
    import lcell_pkg::*;
#(
    parameter int NDATA = LC_NDATA
) (
    input  logic [(1<<NDATA)-1:0] mask,
    input  lut_route_t            route,
    input  logic [NDATA-1:0]      d,
    input  logic                  cin,
    input  logic                  q,
    output logic                  lut_v
);
    localparam int MASK_W  = 1 << NDATA;
    localparam int CIN_IDX = 2;
    localparam int FB_IDX  = NDATA - 1;

    logic [NDATA-1:0] sel;

    for (genvar i = 0; i < NDATA; i++) begin : g_in
        if (i == CIN_IDX) begin : g_cin
            assign sel[i] = route.cin_sel ? cin : d[i];
        end else if (i == FB_IDX) begin : g_fb
            assign sel[i] = route.fb ? q : d[i];
        end else begin : g_plain
            assign sel[i] = d[i];
        end
    end

    logic [MASK_W-1:0] onehot;
    always_comb begin
        onehot = '0;
        onehot[sel] = 1'b1;
    end
    assign lut_v = |(onehot & mask);

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg
    import lcell_pkg::*;
(
    input  logic     clk,
    input  logic     aclr,
    input  reg_ctl_t ctl,
    input  reg_src_e src,
    input  logic     lut_v,
    input  logic     pack_v,
    input  logic     chain_v,
    output logic     q
);
    logic nxt;

    always_comb begin
        unique case (src)
            SRC_PACK:  nxt = pack_v;
            SRC_CHAIN: nxt = chain_v;
            default:   nxt = lut_v;
        endcase
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            q <= 1'b0;
        end else if (ctl.ena) begin
            if (ctl.sclr)       q <= 1'b0;
            else if (ctl.sload) q <= pack_v;
            else                q <= nxt;
        end
    end

    // R4: clear wins at every sampled edge
    a_r4_async_clear: assert property (@(posedge clk)
        aclr |-> (q == 1'b0));

    // R5
    a_r5_hold_when_disabled: assert property (@(posedge clk) disable iff (aclr)
        !ctl.ena |=> $stable(q));

    // R6
    a_r6_sync_clear: assert property (@(posedge clk) disable iff (aclr)
        (ctl.ena && ctl.sclr) |=> (q == 1'b0));

    // R7
    a_r7_sync_load: assert property (@(posedge clk) disable iff (aclr)
        (ctl.ena && !ctl.sclr && ctl.sload) |=> (q == $past(pack_v)));

    // R8, R9: chain source shifts in the neighbour's bit
    a_r9_chain_shift: assert property (@(posedge clk) disable iff (aclr)
        (ctl.ena && !ctl.sclr && !ctl.sload && src == SRC_CHAIN)
        |=> (q == $past(chain_v)));

    // R8: LUT source captures the combinational result
    a_r8_lut_capture: assert property (@(posedge clk) disable iff (aclr)
        (ctl.ena && !ctl.sclr && !ctl.sload && src_is_lut(src))
        |=> (q == $past(lut_v)));

endmodule

// File: rtl/lcell_outsel.sv
module lcell_outsel #(
    parameter int NOUT = lcell_pkg::LC_NOUT
) (
    input  logic [NOUT-1:0] use_reg,
    input  logic            q,
    input  logic            lut_v,
    output logic [NOUT-1:0] route
);
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        assign route[i] = use_reg[i] ? q : lut_v;
    end
endmodule

// File: rtl/lcell.sv
module lcell
    import lcell_pkg::*;
#(
    parameter int NDATA = LC_NDATA,
    parameter int NOUT  = LC_NOUT
) (
    input  logic                  clk,
    input  logic                  aclr,
    input  logic                  ena,
    input  logic                  sclr,
    input  logic                  sload,
    input  logic [(1<<NDATA)-1:0] cfg_lut,
    input  logic                  cfg_cin_sel,
    input  logic                  cfg_fb,
    input  logic [1:0]            cfg_src,
    input  logic [NOUT-1:0]       cfg_oreg,
    input  logic [NDATA-1:0]      d_in,
    input  logic                  cin,
    input  logic                  chain_in,
    output logic [NOUT-1:0]       route_o,
    output logic                  chain_out
);
    localparam int PACK_IDX = NDATA - 1;

    reg_ctl_t   ctl;
    lut_route_t rte;
    reg_src_e   src;
    logic       q;
    logic       lut_v;

    assign ctl = '{ena: ena, sclr: sclr, sload: sload};
    assign rte = '{cin_sel: cfg_cin_sel, fb: cfg_fb};
    assign src = reg_src_e'(cfg_src);

    lcell_lut #(.NDATA(NDATA)) u_lut (
        .mask  (cfg_lut),
        .route (rte),
        .d     (d_in),
        .cin   (cin),
        .q     (q),
        .lut_v (lut_v)
    );

    lcell_reg u_reg (
        .clk     (clk),
        .aclr    (aclr),
        .ctl     (ctl),
        .src     (src),
        .lut_v   (lut_v),
        .pack_v  (d_in[PACK_IDX]),
        .chain_v (chain_in),
        .q       (q)
    );

    lcell_outsel #(.NOUT(NOUT)) u_out (
        .use_reg (cfg_oreg),
        .q       (q),
        .lut_v   (lut_v),
        .route   (route_o)
    );

    assign chain_out = q;

endmodule

// File: tb/lcell_tb.sv
`timescale 1ns/100ps
module lcell_tb;
    localparam int NC = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic aclr = 1'b1, ena = 1'b0, sclr = 1'b0, sload = 1'b0, head = 1'b0;
    logic [15:0] c_lut  [NC];
    logic        c_csel [NC];
    logic        c_fb   [NC];
    logic [1:0]  c_src  [NC];
    logic [2:0]  c_oreg [NC];
    logic [3:0]  d      [NC];
    logic        cin    [NC];
    logic [2:0]  route  [NC];
    logic        cout   [NC];
    logic        q_m    [NC];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    for (genvar k = 0; k < NC; k++) begin : g_cell
        logic ch_in;
        if (k == 0) begin : g_h
            assign ch_in = head;
        end else begin : g_n
            assign ch_in = cout[k-1];
        end
        if (k == 0) begin : g_dut
            lcell u_dut (.clk(clk), .aclr(aclr), .ena(ena), .sclr(sclr), .sload(sload),
                .cfg_lut(c_lut[k]), .cfg_cin_sel(c_csel[k]), .cfg_fb(c_fb[k]),
                .cfg_src(c_src[k]), .cfg_oreg(c_oreg[k]), .d_in(d[k]), .cin(cin[k]),
                .chain_in(ch_in), .route_o(route[k]), .chain_out(cout[k]));
        end else begin : g_nb
            lcell u_cell (.clk(clk), .aclr(aclr), .ena(ena), .sclr(sclr), .sload(sload),
                .cfg_lut(c_lut[k]), .cfg_cin_sel(c_csel[k]), .cfg_fb(c_fb[k]),
                .cfg_src(c_src[k]), .cfg_oreg(c_oreg[k]), .d_in(d[k]), .cin(cin[k]),
                .chain_in(ch_in), .route_o(route[k]), .chain_out(cout[k]));
        end
    end

    function automatic logic lut_eval(input logic [15:0] m, input logic [3:0] dd,
                                      input logic ci, input logic qq,
                                      input logic cs, input logic fb);
        logic [3:0] idx;
        idx = {fb ? qq : dd[3], cs ? ci : dd[2], dd[1], dd[0]};
        return m[idx];
    endfunction

    function automatic logic cell_lut(input int k);
        return lut_eval(c_lut[k], d[k], cin[k], q_m[k], c_csel[k], c_fb[k]);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // combinational outputs against the model (inputs already settled)
    task automatic check_comb();
        for (int k = 0; k < NC; k++)
            for (int i = 0; i < 3; i++)
                check(c_oreg[k][i] ? "R10" : "R1", route[k][i],
                      c_oreg[k][i] ? q_m[k] : cell_lut(k));
    endtask

    // advance one edge: model next state, then check chain_out after the edge
    task automatic step();
        logic nq [NC];
        string tg;
        for (int k = 0; k < NC; k++) begin
            logic chv;
            chv = (k == 0) ? head : q_m[k-1];
            nq[k] = q_m[k];
            if (aclr) nq[k] = 1'b0;
            else if (ena) begin
                if (sclr)       nq[k] = 1'b0;
                else if (sload) nq[k] = d[k][3];
                else case (c_src[k])
                    2'd1:    nq[k] = d[k][3];
                    2'd2:    nq[k] = chv;
                    default: nq[k] = cell_lut(k);
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            q_m[k] = nq[k];
            if (aclr)              tg = "R4";
            else if (!ena)         tg = "R5";
            else if (sclr)         tg = "R6";
            else if (sload)        tg = "R7";
            else if (c_src[k] == 2) tg = "R9";
            else                   tg = "R8";
            check(tg, cout[k], q_m[k]);
        end
    endtask

    task automatic cycle();
        #1 check_comb();
        step();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < NC; k++) begin
            c_lut[k] = 16'h0; c_csel[k] = 0; c_fb[k] = 0; c_src[k] = 0;
            c_oreg[k] = 3'b000; d[k] = 4'h0; cin[k] = 0; q_m[k] = 0;
        end
        #1;
        // reset state (R4)
        for (int k = 0; k < NC; k++) check("R4", cout[k], 1'b0);
        step();
        @(negedge clk);
        aclr = 0;

        // R1: parity mask over all 16 input combinations, combinational outputs
        c_lut[0] = 16'h6996;
        for (int v = 0; v < 16; v++) begin
            d[0] = v[3:0];
            #1 check("R1", route[0][0], ^v[3:0]);
        end

        // R2: cin replaces input 2; ignored when not selected
        c_lut[0] = 16'hF0F0; d[0] = 4'b0000;
        c_csel[0] = 1; cin[0] = 1; #1 check("R2", route[0][1], 1'b1);
        cin[0] = 0;                #1 check("R2", route[0][1], 1'b0);
        c_csel[0] = 0; cin[0] = 1; #1 check("R2", route[0][1], 1'b0);
        d[0] = 4'b0100;            #1 check("R2", route[0][1], 1'b1);

        // R3: feedback replaces input 3; d_in[3] ignored
        c_lut[0] = 16'hFF00; ena = 1; sload = 1; d[0] = 4'b1000;
        step();
        sload = 0; ena = 0; c_fb[0] = 1; d[0] = 4'b0000;
        #1 check("R3", route[0][2], 1'b1);
        d[0] = 4'b1000; #1 check("R3", route[0][2], 1'b1);
        c_fb[0] = 0; d[0] = 4'b0000; #1 check("R3", route[0][2], 1'b0);

        // R6 over R7
        ena = 1; sclr = 1; sload = 1; d[0] = 4'b1000;
        cycle();
        sclr = 0; sload = 0;

        // R9: shift a pattern through the chain while LUTs compute parity
        for (int k = 0; k < NC; k++) begin
            c_src[k] = 2; c_lut[k] = 16'h6996; c_oreg[k] = 3'b010;
        end
        for (int t = 0; t < 12; t++) begin
            head = t[0] ^ t[2];
            for (int k = 0; k < NC; k++) d[k] = 4'($urandom);
            cycle();
        end

        // R4: asynchronous clear mid-cycle, before any edge
        aclr = 1;
        #1 for (int k = 0; k < NC; k++) check("R4", cout[k], 1'b0);
        for (int k = 0; k < NC; k++) q_m[k] = 0;
        step();
        aclr = 0;

        // constrained random mix
        for (int t = 0; t < 3000; t++) begin
            if (t % 200 == 0)
                for (int k = 0; k < NC; k++) begin
                    c_lut[k] = 16'($urandom); c_csel[k] = 1'($urandom);
                    c_fb[k] = 1'($urandom); c_src[k] = 2'($urandom);
                    c_oreg[k] = 3'($urandom);
                end
            ena   = ($urandom % 4) != 0;
            sclr  = ($urandom % 8) == 0;
            sload = ($urandom % 6) == 0;
            head  = 1'($urandom);
            for (int k = 0; k < NC; k++) begin
                d[k] = 4'($urandom); cin[k] = 1'($urandom);
            end
            if (($urandom % 97) == 0) begin
                aclr = 1;
                #1 for (int k = 0; k < NC; k++) check("R4", cout[k], 1'b0);
                for (int k = 0; k < NC; k++) q_m[k] = 0;
                step();
                aclr = 0;
            end else begin
                cycle();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule